// File: doc/BRIEF.md
# RMII Receive Frame Byte Formatter

This block sits behind the 2-bit reduced media-independent receive interface of a 100 Mbit/s Ethernet PHY. It samples one dibit per 50 MHz clock and rebuilds the received frame as bytes on an 8-bit parallel bus. A new byte appears every four clocks, which is 12.5 MHz. The bus and its companion signals are meant to be probed with a logic analyser or a mixed-signal oscilloscope. The timing and content of each frame can then be viewed next to other system signals, or used to trigger on them.

While the preamble is being received, the two lowest bus bits act as live trigger flags. Bit 0 rises as soon as carrier-sense/data-valid is seen. Bit 1 rises when the start frame delimiter is found. Once the delimiter has passed, all eight bits carry frame data. A separate gate is high from the first address byte through the last byte of the frame check sequence, so a scope can trigger on it directly or measure the frame length with it. A one-cycle strobe marks each new byte. A one-cycle pulse reports each assertion of the receive-error input. The block does not check the CRC, parse upper-layer protocols, support 10 Mbit/s operation or transmit.

Top module: `rmiiRxFormatter`

## Requirements
- R1: After reset, `byteBus` is 0x00, and `byteValid`, `frameGate` and `errPulse` are all 0.
- R2: In the cycle after `crsDv` is first sampled high from idle, `byteBus` reads 0x01 (bit 0 is the carrier flag). This value holds until the delimiter is found.
- R3: During the preamble, an `rxd` dibit of 2'b11 whose preceding dibit was 2'b01 is taken as the delimiter. In the next cycle `byteBus` reads 0x03 (bit 1 is the delimiter flag), and it holds 0x03 until the first byte is complete.
- R4: A 2'b11 dibit whose preceding dibit was not 2'b01 is not a delimiter: `byteBus` stays 0x01.
- R5: After the delimiter, each group of four dibits forms one byte, least significant pair first (dibit k supplies bits 2k+1:2k). The byte appears on `byteBus` in the cycle after its fourth dibit is sampled and holds for four cycles.
- R6: `byteValid` is high for exactly one cycle with each new byte on `byteBus`, and never outside `frameGate`.
- R7: `frameGate` rises together with the first byte. It stays high through the last byte and falls, with `byteBus` returning to 0x00, in the cycle after `crsDv` is sampled low.
- R8: If `crsDv` drops part way through a byte, the partial byte is discarded: no `byteValid` follows.
- R9: `errPulse` is high for one cycle after `rxEr` is first sampled high. If `rxEr` is held high, only one pulse is produced.
- R10: After the delimiter, bits 0 and 1 of `byteBus` carry frame data, so a byte of 0x00 clears both flags and a byte of 0xFC has both low.
- R11: A frame that follows an idle gap starts again from the carrier flag (0x01), and its first byte re-raises `frameGate`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxd | input | 2 | Receive dibit from the PHY |
| crsDv | input | 1 | Combined carrier-sense / data-valid |
| rxEr | input | 1 | Receive error from the PHY |
| byteBus | output | 8 | Flags during the preamble, frame bytes afterwards |
| byteValid | output | 1 | One-cycle strobe for each new byte |
| frameGate | output | 1 | High over the frame bytes through the check sequence |
| errPulse | output | 1 | One-cycle pulse on each receive-error assertion |

## Verification
The assertions check properties that must hold on every cycle:
- the byte strobe is a single cycle and lies inside the gate;
- loss of carrier closes the gate and clears the bus on the next cycle;
- each error assertion yields one pulse and never two in a row;
- the control strobes stay mutually exclusive.

Only the bench scenarios can show the data-dependent behaviour:
- the order in which dibits are packed into a byte;
- telling a real delimiter from a stray 2'b11;
- how long the 0x01 and 0x03 flag values are held;
- dropping a partial byte;
- restarting cleanly on a second frame.

// File: rtl/rmiiFmtPkg.sv
package rmiiFmtPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } fmtState_t;

  // Strobes from control to datapath; at most one of the first four is set,
  // byteDone only accompanies shift.
  typedef struct packed {
    logic clear;
    logic preamble;
    logic sfdHit;
    logic shift;
    logic byteDone;
  } fmtStrobe_t;

  localparam logic [1:0] PRE_DIBIT = 2'b01;
  localparam logic [1:0] SFD_DIBIT = 2'b11;

endpackage

// File: rtl/rmiiFmtCtrl.sv
module rmiiFmtCtrl
  import rmiiFmtPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int DIBIT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIBIT_W-1:0] rxd,
  input  logic               crsDv,
  output fmtStrobe_t         strobe
);

  localparam int DIBITS = BYTE_W / DIBIT_W;
  localparam int CNT_W  = (DIBITS > 1) ? $clog2(DIBITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIBITS - 1);

  fmtState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic             prevPre;
  logic             sfdSeen;

  assign sfdSeen = crsDv && prevPre && (rxd == DIBIT_W'(SFD_DIBIT));

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (crsDv) begin
          stateNxt        = ST_PRE;
          strobe.preamble = 1'b1;
        end else begin
          strobe.clear = 1'b1;
        end
      end
      ST_PRE: begin
        if (!crsDv) begin
          stateNxt     = ST_IDLE;
          strobe.clear = 1'b1;
        end else if (sfdSeen) begin
          stateNxt      = ST_DATA;
          strobe.sfdHit = 1'b1;
        end
      end
      ST_DATA: begin
        if (!crsDv) begin
          stateNxt     = ST_IDLE;
          strobe.clear = 1'b1;
        end else begin
          strobe.shift    = 1'b1;
          strobe.byteDone = (cnt == LAST);
        end
      end
      default: begin
        stateNxt     = ST_IDLE;
        strobe.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      prevPre <= 1'b0;
    end else begin
      state   <= stateNxt;
      prevPre <= crsDv && (rxd == DIBIT_W'(PRE_DIBIT));
      if (strobe.shift) cnt <= cnt + 1'b1;
      else              cnt <= '0;
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clear, strobe.preamble, strobe.sfdHit, strobe.shift}));

  p_done_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteDone |=> !strobe.byteDone);

  p_done_needs_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteDone |-> strobe.shift && crsDv);

endmodule

// File: rtl/rmiiFmtDatapath.sv
module rmiiFmtDatapath
  import rmiiFmtPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int DIBIT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIBIT_W-1:0] rxd,
  input  fmtStrobe_t         strobe,
  output logic [BYTE_W-1:0]  byteBus,
  output logic               byteValid,
  output logic               frameGate
);

  localparam int SH_W = BYTE_W - DIBIT_W;
  localparam logic [BYTE_W-1:0] FLAG_CARRIER = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] FLAG_SFD     = BYTE_W'(3);

  logic [SH_W-1:0]   shiftReg;
  logic [BYTE_W-1:0] assembled;

  assign assembled = {rxd, shiftReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      byteBus   <= '0;
      byteValid <= 1'b0;
      frameGate <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      if (strobe.clear) begin
        byteBus   <= '0;
        frameGate <= 1'b0;
      end else if (strobe.preamble) begin
        byteBus <= FLAG_CARRIER;
      end else if (strobe.sfdHit) begin
        byteBus <= FLAG_SFD;
      end else if (strobe.shift) begin
        shiftReg <= assembled[BYTE_W-1:DIBIT_W];
        if (strobe.byteDone) begin
          byteBus   <= assembled;
          byteValid <= 1'b1;
          frameGate <= 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  p_clear_closes_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !frameGate && (byteBus == '0));

endmodule

// File: rtl/rmiiErrPulse.sv
module rmiiErrPulse (
  input  logic clk,
  input  logic rstN,
  input  logic rxEr,
  output logic errPulse
);

  logic errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ     <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errQ     <= rxEr;
      errPulse <= rxEr && !errQ;
    end
  end

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  p_err_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(rxEr));

endmodule

// File: rtl/rmiiRxFormatter.sv
module rmiiRxFormatter
  import rmiiFmtPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int DIBIT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIBIT_W-1:0] rxd,
  input  logic               crsDv,
  input  logic               rxEr,
  output logic [BYTE_W-1:0]  byteBus,
  output logic               byteValid,
  output logic               frameGate,
  output logic               errPulse
);

  fmtStrobe_t strobe;

  rmiiFmtCtrl #(.BYTE_W(BYTE_W), .DIBIT_W(DIBIT_W)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rxd    (rxd),
    .crsDv  (crsDv),
    .strobe (strobe)
  );

  rmiiFmtDatapath #(.BYTE_W(BYTE_W), .DIBIT_W(DIBIT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxd       (rxd),
    .strobe    (strobe),
    .byteBus   (byteBus),
    .byteValid (byteValid),
    .frameGate (frameGate)
  );

  rmiiErrPulse i_err (
    .clk      (clk),
    .rstN     (rstN),
    .rxEr     (rxEr),
    .errPulse (errPulse)
  );

  p_valid_in_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> frameGate);

  p_carrier_loss_r7: assert property (@(posedge clk) disable iff (!rstN)
    !crsDv |=> !frameGate && !byteValid && (byteBus == '0));

endmodule

// File: tb/test_rmiiRxFormatter.sv
module test_rmiiRxFormatter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       crsDv = 1'b0;
  logic       rxEr = 1'b0;
  logic [7:0] byteBus;
  logic       byteValid;
  logic       frameGate;
  logic       errPulse;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  rmiiRxFormatter i_rmiiRxFormatter (
    .clk(clk), .rstN(rstN), .rxd(rxd), .crsDv(crsDv), .rxEr(rxEr),
    .byteBus(byteBus), .byteValid(byteValid), .frameGate(frameGate),
    .errPulse(errPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one dibit, then look just after the edge that samples it.
  task automatic step(input logic crs, input logic [1:0] d);
    @(negedge clk);
    crsDv = crs;
    rxd   = d;
    @(posedge clk);
    #1;
  endtask

  task automatic preambleToSfd();
    step(1'b1, 2'b01);
    check("R2 carrier flag", byteBus, 8'h01);
    for (int i = 0; i < 6; i++) step(1'b1, 2'b01);
    check("R2 flag held", byteBus, 8'h01);
    step(1'b1, 2'b11);
    check("R3 sfd flag", byteBus, 8'h03);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic [7:0] prev);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, b[2*k +: 2]);
      check("R5 bus holds mid-byte", byteBus, prev);
      check("R6 no strobe mid-byte", byteValid, 0);
    end
    step(1'b1, b[7:6]);
    check("R5 byte assembled", byteBus, b);
    check("R6 strobe with byte", byteValid, 1);
    check("R7 gate high", frameGate, 1);
  endtask

  task automatic testReset();
    check("R1 bus", byteBus, 0);
    check("R1 valid", byteValid, 0);
    check("R1 gate", frameGate, 0);
    check("R1 err", errPulse, 0);
  endtask

  task automatic testFrame();
    preambleToSfd();
    check("R7 gate low before data", frameGate, 0);
    sendByte(8'hA6, 8'h03);
    sendByte(8'h00, 8'hA6);
    check("R10 flag bits carry data", byteBus[1:0], 0);
    sendByte(8'hFC, 8'h00);
    sendByte(8'h1B, 8'hFC);
    step(1'b0, 2'b00);
    check("R7 gate falls", frameGate, 0);
    check("R7 bus cleared", byteBus, 0);
    check("R6 no strobe at end", byteValid, 0);
  endtask

  task automatic testFalseSfd();
    step(1'b1, 2'b00);
    check("R2 flag from 00", byteBus, 8'h01);
    step(1'b1, 2'b11);
    check("R4 11 after 00 ignored", byteBus, 8'h01);
    step(1'b1, 2'b10);
    step(1'b1, 2'b11);
    check("R4 11 after 10 ignored", byteBus, 8'h01);
    step(1'b1, 2'b01);
    step(1'b1, 2'b11);
    check("R3 real sfd", byteBus, 8'h03);
    sendByte(8'h5A, 8'h03);
    step(1'b0, 2'b00);
    check("R11 idle after frame", byteBus, 0);
  endtask

  task automatic testPartial();
    int seen = 0;
    preambleToSfd();
    sendByte(8'h3C, 8'h03);
    step(1'b1, 2'b10);
    seen += byteValid;
    step(1'b1, 2'b01);
    seen += byteValid;
    step(1'b0, 2'b00);
    seen += byteValid;
    step(1'b0, 2'b00);
    seen += byteValid;
    check("R8 partial byte dropped", seen, 0);
    check("R8 gate closed", frameGate, 0);
  endtask

  task automatic testSecondFrame();
    for (int i = 0; i < 5; i++) step(1'b0, 2'b00);
    check("R11 idle bus", byteBus, 0);
    preambleToSfd();
    sendByte(8'hC3, 8'h03);
    check("R11 gate re-raised", frameGate, 1);
    step(1'b0, 2'b00);
    check("R11 gate closes", frameGate, 0);
  endtask

  task automatic testError();
    @(negedge clk);
    rxEr = 1'b1;
    @(posedge clk); #1;
    check("R9 pulse", errPulse, 1);
    @(posedge clk); #1;
    check("R9 single pulse", errPulse, 0);
    @(posedge clk); #1;
    check("R9 held no repeat", errPulse, 0);
    @(negedge clk);
    rxEr = 1'b0;
    @(negedge clk);
    rxEr = 1'b1;
    @(posedge clk); #1;
    check("R9 second pulse", errPulse, 1);
    @(negedge clk);
    rxEr = 1'b0;
    @(posedge clk); #1;
    check("R9 pulse ends", errPulse, 0);
  endtask

  initial begin
    #2_000_000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 2'b00);
    testReset();
    testFrame();
    testFalseSfd();
    testPartial();
    testSecondFrame();
    testError();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule